// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital input stage of a 16-bit voltage-output converter. A host sends a 24-bit word over three wires: a serial clock, an active-low frame select and a data line. While frame select is low, the block samples the data line on each falling edge of the serial clock. When the frame is complete it loads a 16-bit converter code and a 2-bit power-down mode in one step. A frame that ends early is thrown away, and the previous code and mode stay in force.

The serial lines are brought into the system clock domain through synchronizer flops, and falling edges are detected there. The serial clock must therefore run at no more than a quarter of the system clock rate. The outputs are the current code, the power-down mode and a one-cycle update strobe that marks each commit. At reset the code takes one of two fixed values, selected by a parameter, and the mode returns to normal.

Top module: `sdac_frame_rx`

## Requirements
- R1: A frame holds 24 bits, most significant bit first. Each bit is the value of `sdi_i` at a falling edge of `sclk_i` seen while `fsel_n_i` is low.
- R2: Frame bits 23 down to 18 are header bits and have no effect on any output.
- R3: Frame bits 17:16 form the mode field and are driven on `pd_mode_o` as received: 2'b00 normal, 2'b01 off with 1 kΩ to ground, 2'b10 off with 100 kΩ to ground, 2'b11 off with the output three-stated.
- R4: Frame bits 15:0 form the converter code, with bit 0 as the least significant bit, and are driven on `dac_code_o`.
- R5: Code and mode change together, only on the 24th falling edge of a frame. They become visible, together with `upd_o`, at the fourth rising edge of `clk` after the 24th falling edge appears at the pins.
- R6: If `fsel_n_i` rises before the 24th falling edge, the partial frame is discarded. Code and mode keep their values and `upd_o` stays low.
- R7: Reset (`rst` high, synchronous) sets `pd_mode_o` to 2'b00 and `upd_o` to 0. It sets `dac_code_o` to 16'h0000 when `RESET_MIDSCALE` is 0 and to 16'h8000 when it is 1.
- R8: The reset code and mode stay on the outputs until the first complete frame is received, even if aborted frames arrive first.
- R9: Falling edges after the 24th within one frame are ignored. After `fsel_n_i` rises and falls again, the next frame counts from bit zero.
- R10: `upd_o` is high for exactly one `clk` cycle for each committed frame and never for an aborted frame.
- R11: All three serial inputs pass through `SYNC_STAGES` synchronizer flops. A serial clock at one quarter of the `clk` rate (two cycles high, two cycles low) is received without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| fsel_n_i | input | 1 | Frame select, active low |
| sdi_i | input | 1 | Serial data in |
| dac_code_o | output | 16 | Current converter code |
| pd_mode_o | output | 2 | Current power-down mode |
| upd_o | output | 1 | One-cycle strobe on each commit |

## Verification
A committed frame shows up four rising edges of `clk` after its 24th falling serial edge is driven: two synchronizer stages, the edge-detect and shift stage, and the output register. The driver records the cycle number at which it drops the serial clock for the 24th time and queues the expected code, mode and due cycle. The monitor samples on the falling edge of `clk` and requires each strobe to arrive exactly on the cycle it was due. Aborted frames and the edges that follow a full frame queue nothing, so any strobe they produce has no queued entry and is reported. After each such sequence the outputs are also compared, once the four-cycle pipeline has drained, against the last committed value.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;
    localparam int CODE_W  = 16;
    localparam int MODE_W  = 2;
    localparam int PAD_W   = 6;
    localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
    localparam int KEEP_W  = MODE_W + CODE_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [MODE_W-1:0] {
        PD_NORMAL   = 2'b00,
        PD_GND_1K   = 2'b01,
        PD_GND_100K = 2'b10,
        PD_HIGHZ    = 2'b11
    } pd_mode_e;

    typedef struct packed {
        pd_mode_e            mode;
        logic [CODE_W-1:0]   code;
    } word_t;

    function automatic logic [CODE_W-1:0] reset_code(input bit midscale);
        return midscale ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
    endfunction
endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VEC = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VEC;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= RST_VEC;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
`timescale 1ns/1ps
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              fsel_n_s,
    input  logic              sdi_s,
    output logic [KEEP_W-1:0] keep_q,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              commit_v
);
    logic sclk_d;
    logic fall;
    logic last_bit;
    logic full;

    assign fall     = sclk_d & ~sclk_s;
    assign last_bit = (bit_cnt == CNT_W'(FRAME_W - 1));
    assign full     = (bit_cnt == CNT_W'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b1;
            keep_q   <= '0;
            bit_cnt  <= '0;
            commit_v <= 1'b0;
        end else begin
            sclk_d   <= sclk_s;
            commit_v <= 1'b0;
            if (fsel_n_s) begin
                bit_cnt <= '0;
                keep_q  <= '0;
            end else if (fall && !full) begin
                keep_q   <= {keep_q[KEEP_W-2:0], sdi_s};
                bit_cnt  <= bit_cnt + 1'b1;
                commit_v <= last_bit;
            end
        end
    end
endmodule

// File: rtl/sdac_commit.sv
`timescale 1ns/1ps
module sdac_commit
    import sdac_pkg::*;
#(
    parameter bit RESET_MIDSCALE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_v,
    input  word_t             word,
    output logic [CODE_W-1:0] code_q,
    output pd_mode_e          mode_q,
    output logic              upd_q
);
    localparam logic [CODE_W-1:0] CODE_RST = reset_code(RESET_MIDSCALE);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= CODE_RST;
            mode_q <= PD_NORMAL;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= commit_v;
            if (commit_v) begin
                code_q <= word.code;
                mode_q <= word.mode;
            end
        end
    end
endmodule

// File: rtl/sdac_frame_rx.sv
`timescale 1ns/1ps
module sdac_frame_rx
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter bit RESET_MIDSCALE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              fsel_n_i,
    input  logic              sdi_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic [MODE_W-1:0] pd_mode_o,
    output logic              upd_o
);
    localparam int LANES = 3;

    logic [LANES-1:0]  raw_lines;
    logic [LANES-1:0]  sync_lines;
    logic              sclk_s;
    logic              fsel_n_s;
    logic              sdi_s;
    logic [KEEP_W-1:0] keep_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic              commit_v;
    pd_mode_e          mode_q;

    assign raw_lines = {sclk_i, fsel_n_i, sdi_i};
    assign {sclk_s, fsel_n_s, sdi_s} = sync_lines;

    sdac_sync #(
        .W       (LANES),
        .STAGES  (SYNC_STAGES),
        .RST_VEC (3'b110)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    sdac_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (sclk_s),
        .fsel_n_s (fsel_n_s),
        .sdi_s    (sdi_s),
        .keep_q   (keep_q),
        .bit_cnt  (bit_cnt),
        .commit_v (commit_v)
    );

    sdac_commit #(
        .RESET_MIDSCALE (RESET_MIDSCALE)
    ) u_commit (
        .clk      (clk),
        .rst      (rst),
        .commit_v (commit_v),
        .word     (word_t'(keep_q)),
        .code_q   (dac_code_o),
        .mode_q   (mode_q),
        .upd_q    (upd_o)
    );

    assign pd_mode_o = mode_q;
endmodule

// File: rtl/sdac_frame_rx_chk.sv
`timescale 1ns/1ps
module sdac_frame_rx_chk
    import sdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              upd,
    input logic [CODE_W-1:0] code,
    input logic [MODE_W-1:0] mode,
    input logic              fsel_n_s,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              commit_v
);
    AST_UPD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd);                                             // R10

    AST_HOLD_WITHOUT_UPD: assert property (@(posedge clk) disable iff (rst)
        !upd |-> ($stable(code) && $stable(mode)));                // R6

    AST_COMMIT_TO_UPD: assert property (@(posedge clk) disable iff (rst)
        commit_v |=> upd);                                         // R5

    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        fsel_n_s |=> (bit_cnt == '0));                             // R6

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME_W));                               // R9

    AST_COMMIT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        commit_v |-> $past(!fsel_n_s));                            // R1
endmodule

bind sdac_frame_rx sdac_frame_rx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd_o),
    .code     (dac_code_o),
    .mode     (pd_mode_o),
    .fsel_n_s (fsel_n_s),
    .bit_cnt  (bit_cnt),
    .commit_v (commit_v)
);

// File: tb/tb_sdac_frame_rx.sv
`timescale 1ns/1ps
module tb_sdac_frame_rx;
    import sdac_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        fsel_n = 1'b1;
    logic        sdi = 1'b0;
    logic [15:0] code, code_mid;
    logic [1:0]  mode, mode_mid;
    logic        upd, upd_mid;

    always #2 clk = ~clk;

    sdac_frame_rx dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .fsel_n_i(fsel_n), .sdi_i(sdi),
        .dac_code_o(code), .pd_mode_o(mode), .upd_o(upd)
    );

    sdac_frame_rx #(.RESET_MIDSCALE(1'b1)) dut_mid (
        .clk(clk), .rst(rst), .sclk_i(sclk), .fsel_n_i(fsel_n), .sdi_i(sdi),
        .dac_code_o(code_mid), .pd_mode_o(mode_mid), .upd_o(upd_mid)
    );

    typedef struct {
        logic [15:0] code;
        logic [1:0]  mode;
        int          due;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   commits = 0;
    bit   fin = 1'b0;
    logic prev_upd = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    // Monitor: pops the scoreboard whenever a strobe appears
    always @(negedge clk) begin
        exp_t e;
        if (!rst && !fin) begin
            if (upd && prev_upd) chk("R10 strobe longer than one cycle", 32'd1, 32'd0);
            if (upd) begin
                commits++;
                if (q.size() == 0) begin
                    chk("R10 strobe with nothing committed", 32'd1, 32'd0);
                end else begin
                    e = q.pop_front();
                    chk("R4 code", {16'd0, code}, {16'd0, e.code});
                    chk("R3 mode", {30'd0, mode}, {30'd0, e.mode});
                    chk("R5 due cycle", cyc, e.due);
                end
            end
            prev_upd = upd;
        end
    end

    // Driver: nbits edges, then extra edges after the frame, then deselect.
    // Serial clock runs two cycles high, two cycles low (R11).
    task automatic send(input logic [23:0] w, input int nbits, input int extra);
        exp_t e;
        @(negedge clk) fsel_n = 1'b0;
        for (int i = 0; i < nbits + extra; i++) begin
            @(negedge clk) sdi = (i < 24) ? w[23-i] : logic'(i[0]);
            @(negedge clk) sclk = 1'b0;
            if (i == 23) begin
                e.code = w[15:0];
                e.mode = w[17:16];
                e.due  = cyc + 4;
                q.push_back(e);
            end
            repeat (2) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (2) @(negedge clk);
        fsel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic settle_and_compare(input string req, input logic [15:0] c, input logic [1:0] m);
        repeat (8) @(negedge clk);
        chk({req, " code"}, {16'd0, code}, {16'd0, c});
        chk({req, " mode"}, {30'd0, mode}, {30'd0, m});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset values for both variants
        chk("R7 code zero variant", {16'd0, code}, 32'h0);
        chk("R7 code midscale variant", {16'd0, code_mid}, 32'h8000);
        chk("R7 mode", {30'd0, mode}, 32'h0);
        chk("R7 mode midscale variant", {30'd0, mode_mid}, 32'h0);
        chk("R7 strobe", {31'd0, upd}, 32'h0);
        @(negedge clk) rst = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 code holds", {16'd0, code_mid}, 32'h8000);
        // R6/R8: short frame after 10 bits
        send(24'h02_FFFF, 10, 0);
        settle_and_compare("R6 R8 abort at 10", 16'h0000, 2'b00);
        chk("R8 midscale survives abort", {16'd0, code_mid}, 32'h8000);
        // R1 R4: plain frame
        send({6'h00, 2'b00, 16'h1234}, 24, 0);
        settle_and_compare("R1 R4 frame", 16'h1234, 2'b00);
        // R2 R3: header all ones, three-state mode
        send({6'h3F, 2'b11, 16'hFFFF}, 24, 0);
        settle_and_compare("R2 R3 header ignored", 16'hFFFF, 2'b11);
        // R4: LSB position, 1k mode
        send({6'h15, 2'b01, 16'h0001}, 24, 0);
        settle_and_compare("R4 lsb", 16'h0001, 2'b01);
        send({6'h2A, 2'b10, 16'h8000}, 24, 0);
        settle_and_compare("R3 100k mode", 16'h8000, 2'b10);
        // R6: abort one edge short of completion
        send({6'h00, 2'b01, 16'h7777}, 23, 0);
        settle_and_compare("R6 abort at 23", 16'h8000, 2'b10);
        // R9: extra edges after the 24th ignored
        send({6'h0C, 2'b01, 16'hA5C3}, 24, 5);
        settle_and_compare("R9 extra edges", 16'hA5C3, 2'b01);
        // R9: next frame starts from bit zero
        send({6'h00, 2'b00, 16'h0F0F}, 24, 0);
        settle_and_compare("R9 fresh frame", 16'h0F0F, 2'b00);
        repeat (10) @(negedge clk);
        chk("R10 strobe count", commits, 32'd6);
        chk("R5 scoreboard drained", q.size(), 32'd0);
        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            checks++;
            errors++;
            $display("FAIL R5 watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule